// File: doc/BRIEF.md
# GCD Accelerator with Latency Counter on an AXI4-Lite Slave Port

This block is a memory-mapped peripheral. It computes the greatest common divisor of two 32-bit operands and measures how many clock cycles each computation takes. Software first writes the two operands and then writes a 1 into the start bit of the status word. It polls the ready flag until the flag is set, then reads the result and the cycle count. The count is cleared when an operation is launched. It advances on every cycle the engine is busy and freezes when the result is ready, so software can read the latency of one operation after it finishes.

Inside the block there are two handshake state machines, one for writes and one for reads, a small register file, a subtract-and-compare GCD engine and a cycle counter. The write machine has the states WR_IDLE, WR_HAVE_ADDR, WR_HAVE_DATA, WR_COMMIT and WR_RESP:
- From WR_IDLE it goes to WR_COMMIT if address and data arrive together, to WR_HAVE_ADDR if the address comes alone, or to WR_HAVE_DATA if the data comes alone.
- WR_HAVE_ADDR waits for data and WR_HAVE_DATA waits for an address. Each then goes to WR_COMMIT.
- WR_COMMIT always goes to WR_RESP.
- WR_RESP returns to WR_IDLE on BREADY.

The read machine has the states RD_IDLE, RD_LOAD and RD_RESP. RD_IDLE goes to RD_LOAD on ARVALID. RD_LOAD always goes to RD_RESP, and RD_RESP returns to RD_IDLE on RREADY. The engine has the states ENG_IDLE and ENG_RUN. ENG_IDLE goes to ENG_RUN on a launch, and ENG_RUN goes back to ENG_IDLE when it reaches a terminal operand pair.

Top module: `gcd_axil_accel`

## Requirements
- R1: After reset, the status word reads 0x2 (READY=1, START=0), and operand A, operand B, the result and the count all read 0. BVALID and RVALID are low.
- R2: A write is committed only after both its address and its data have been accepted, in either order or together. BRESP is then 2'b00 and BVALID stays high until BREADY is sampled high.
- R3: A read returns RRESP=2'b00. RVALID and RDATA stay stable until RREADY. Offsets 0x14, 0x18 and 0x1C read as 0.
- R4: Operand A at 0x04 and operand B at 0x08 are read/write. Each WSTRB bit i updates only byte lane i (bits 8i+7..8i).
- R5: In the status word at 0x00, bit 0 (START) is read/write and bit 1 (READY) is read-only. Writes to the result at 0x0C and to the count at 0x10 have no effect.
- R6: Writing 0x00 with WSTRB[0]=1 and WDATA[0]=1 while READY=1 launches an operation on the current A and B. READY then reads 0 until the operation completes.
- R7: The result is gcd(A,B), computed by subtracting the smaller operand from the larger. If one operand is 0 the result is the other operand, and gcd(0,0)=0.
- R8: The count at 0x10 is cleared at launch. It then equals the number of busy cycles, which is one plus the number of subtraction steps. It holds that value until the next launch.
- R9: While an operation is busy, a write of A or B, or another start write, does not change that operation's result or count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| axil_awvalid | input | 1 | Write address valid |
| axil_awready | output | 1 | Write address ready |
| axil_awaddr | input | 5 | Write byte address |
| axil_wvalid | input | 1 | Write data valid |
| axil_wready | output | 1 | Write data ready |
| axil_wdata | input | 32 | Write data |
| axil_wstrb | input | 4 | Write byte enables |
| axil_bvalid | output | 1 | Write response valid |
| axil_bready | input | 1 | Write response ready |
| axil_bresp | output | 2 | Write response code |
| axil_arvalid | input | 1 | Read address valid |
| axil_arready | output | 1 | Read address ready |
| axil_araddr | input | 5 | Read byte address |
| axil_rvalid | output | 1 | Read data valid |
| axil_rready | input | 1 | Read data ready |
| axil_rdata | output | 32 | Read data |
| axil_rresp | output | 2 | Read response code |

## Verification
If the write machine held a wrong state, the bus would stall or a write would commit with a stale address or data lane. The next readback of A or B would expose it within one transaction. If the engine held a wrong state, a wrong result or a wrong READY would show at the first status poll. If the counter took a wrong enable or clear, the count register would be off from the step count computed for the operands. Running a long operation and issuing writes during it shows whether the count is cleared by a start that should have been ignored.

// File: rtl/gcd_axil_pkg.sv
package gcd_axil_pkg;
    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [2:0] {
        IDX_STATUS = 3'd0,
        IDX_OPA    = 3'd1,
        IDX_OPB    = 3'd2,
        IDX_RES    = 3'd3,
        IDX_CNT    = 3'd4
    } reg_idx_e;
endpackage

// File: rtl/axil_wr_fsm.sv
module axil_wr_fsm
    import gcd_axil_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb
);
    typedef enum logic [2:0] {
        WR_IDLE, WR_HAVE_ADDR, WR_HAVE_DATA, WR_COMMIT, WR_RESP
    } wr_state_e;

    wr_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WR_IDLE: begin
                if (awvalid && wvalid) state_nx = WR_COMMIT;
                else if (awvalid)      state_nx = WR_HAVE_ADDR;
                else if (wvalid)       state_nx = WR_HAVE_DATA;
            end
            WR_HAVE_ADDR: if (wvalid)  state_nx = WR_COMMIT;
            WR_HAVE_DATA: if (awvalid) state_nx = WR_COMMIT;
            WR_COMMIT:                 state_nx = WR_RESP;
            WR_RESP:      if (bready)  state_nx = WR_IDLE;
            default:                   state_nx = WR_IDLE;
        endcase
    end

    always_comb begin
        awready = (state == WR_IDLE) || (state == WR_HAVE_DATA);
        wready  = (state == WR_IDLE) || (state == WR_HAVE_ADDR);
        bvalid  = (state == WR_RESP);
        bresp   = RESP_OKAY;
        wr_en   = (state == WR_COMMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
            wr_strb <= '0;
        end else begin
            if (awvalid && awready) wr_addr <= awaddr;
            if (wvalid && wready) begin
                wr_data <= wdata;
                wr_strb <= wstrb;
            end
        end
    end
endmodule

// File: rtl/axil_rd_fsm.sv
module axil_rd_fsm
    import gcd_axil_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);
    typedef enum logic [1:0] {RD_IDLE, RD_LOAD, RD_RESP} rd_state_e;

    rd_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE: if (arvalid) state_nx = RD_LOAD;
            RD_LOAD:              state_nx = RD_RESP;
            RD_RESP: if (rready)  state_nx = RD_IDLE;
            default:              state_nx = RD_IDLE;
        endcase
    end

    always_comb begin
        arready = (state == RD_IDLE);
        rvalid  = (state == RD_RESP);
        rresp   = RESP_OKAY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
            rdata   <= '0;
        end else begin
            if (arvalid && arready) rd_addr <= araddr;
            if (state == RD_LOAD)   rdata   <= rd_data;
        end
    end
endmodule

// File: rtl/gcd_engine.sv
module gcd_engine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         launch,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         busy,
    output logic [W-1:0] result
);
    typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

    eng_state_e   state, state_nx;
    logic [W-1:0] x_q, y_q;
    logic         finish;

    assign finish = (x_q == '0) || (y_q == '0) || (x_q == y_q);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ENG_IDLE: if (launch) state_nx = ENG_RUN;
            ENG_RUN:  if (finish) state_nx = ENG_IDLE;
            default:              state_nx = ENG_IDLE;
        endcase
    end

    always_comb busy = (state == ENG_RUN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            result <= '0;
        end else if (state == ENG_IDLE) begin
            if (launch) begin
                x_q <= op_a;
                y_q <= op_b;
            end
        end else if (finish) begin
            result <= (x_q == '0) ? y_q : x_q;
        end else if (x_q > y_q) begin
            x_q <= x_q - y_q;
        end else begin
            y_q <= y_q - x_q;
        end
    end
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (en)  q <= q + W'(1);
    end
endmodule

// File: rtl/gcd_axil_accel.sv
module gcd_axil_accel
    import gcd_axil_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              aclk,
    input  logic              aresetn,
    input  logic              axil_awvalid,
    output logic              axil_awready,
    input  logic [ADDR_W-1:0] axil_awaddr,
    input  logic              axil_wvalid,
    output logic              axil_wready,
    input  logic [DATA_W-1:0] axil_wdata,
    input  logic [STRB_W-1:0] axil_wstrb,
    output logic              axil_bvalid,
    input  logic              axil_bready,
    output logic [1:0]        axil_bresp,
    input  logic              axil_arvalid,
    output logic              axil_arready,
    input  logic [ADDR_W-1:0] axil_araddr,
    output logic              axil_rvalid,
    input  logic              axil_rready,
    output logic [DATA_W-1:0] axil_rdata,
    output logic [1:0]        axil_rresp
);
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [STRB_W-1:0] wr_strb;
    logic [2:0]        wr_idx, rd_idx;
    logic [DATA_W-1:0] opa_q, opb_q, res_w, cnt_q;
    logic              start_q, eng_busy, launch;

    assign wr_idx = wr_addr[4:2];
    assign rd_idx = rd_addr[4:2];

    axil_wr_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(aclk), .rst_n(aresetn),
        .awvalid(axil_awvalid), .awready(axil_awready), .awaddr(axil_awaddr),
        .wvalid(axil_wvalid), .wready(axil_wready), .wdata(axil_wdata),
        .wstrb(axil_wstrb), .bvalid(axil_bvalid), .bready(axil_bready),
        .bresp(axil_bresp), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_strb(wr_strb)
    );

    axil_rd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk(aclk), .rst_n(aresetn),
        .arvalid(axil_arvalid), .arready(axil_arready), .araddr(axil_araddr),
        .rvalid(axil_rvalid), .rready(axil_rready), .rdata(axil_rdata),
        .rresp(axil_rresp), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    for (genvar i = 0; i < STRB_W; i++) begin : g_lane
        always_ff @(posedge aclk) begin
            if (!aresetn) begin
                opa_q[i*8 +: 8] <= '0;
                opb_q[i*8 +: 8] <= '0;
            end else if (wr_en && wr_strb[i]) begin
                if (wr_idx == IDX_OPA) opa_q[i*8 +: 8] <= wr_data[i*8 +: 8];
                if (wr_idx == IDX_OPB) opb_q[i*8 +: 8] <= wr_data[i*8 +: 8];
            end
        end
    end

    always_ff @(posedge aclk) begin
        if (!aresetn)
            start_q <= 1'b0;
        else if (wr_en && wr_idx == IDX_STATUS && wr_strb[0])
            start_q <= wr_data[0];
    end

    assign launch = wr_en && (wr_idx == IDX_STATUS) && wr_strb[0]
                    && wr_data[0] && !eng_busy;

    gcd_engine #(.W(DATA_W)) u_eng (
        .clk(aclk), .rst_n(aresetn), .launch(launch),
        .op_a(opa_q), .op_b(opb_q), .busy(eng_busy), .result(res_w)
    );

    cycle_counter #(.W(DATA_W)) u_cnt (
        .clk(aclk), .rst_n(aresetn), .clr(launch), .en(eng_busy), .q(cnt_q)
    );

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            IDX_STATUS: rd_data = {{(DATA_W-2){1'b0}}, !eng_busy, start_q};
            IDX_OPA:    rd_data = opa_q;
            IDX_OPB:    rd_data = opb_q;
            IDX_RES:    rd_data = res_w;
            IDX_CNT:    rd_data = cnt_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gcd_axil_chk.sv
module gcd_axil_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bvalid,
    input logic         bready,
    input logic [1:0]   bresp,
    input logic         rvalid,
    input logic         rready,
    input logic [W-1:0] rdata,
    input logic [1:0]   rresp,
    input logic         busy,
    input logic         launch,
    input logic [W-1:0] cnt
);
    // R2
    bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    // R2
    bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> bresp == 2'b00);
    // R3
    rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));
    // R3
    rresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> rresp == 2'b00);
    // R6
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);
    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> cnt == '0);
    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cnt == $past(cnt) + W'(1));
    // R8
    cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !launch |=> $stable(cnt));
endmodule

bind gcd_axil_accel gcd_axil_chk #(.W(DATA_W)) u_chk (
    .clk(aclk), .rst_n(aresetn),
    .bvalid(axil_bvalid), .bready(axil_bready), .bresp(axil_bresp),
    .rvalid(axil_rvalid), .rready(axil_rready), .rdata(axil_rdata),
    .rresp(axil_rresp), .busy(eng_busy), .launch(launch), .cnt(cnt_q)
);

// File: tb/tb_gcd_axil_accel.sv
module tb_gcd_axil_accel;
    localparam int CLK_PERIOD = 10;

    logic        aclk = 1'b0;
    logic        aresetn = 1'b0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [4:0]  awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) aclk = ~aclk;

    gcd_axil_accel dut (
        .aclk(aclk), .aresetn(aresetn),
        .axil_awvalid(awvalid), .axil_awready(awready), .axil_awaddr(awaddr),
        .axil_wvalid(wvalid), .axil_wready(wready), .axil_wdata(wdata),
        .axil_wstrb(wstrb), .axil_bvalid(bvalid), .axil_bready(bready),
        .axil_bresp(bresp), .axil_arvalid(arvalid), .axil_arready(arready),
        .axil_araddr(araddr), .axil_rvalid(rvalid), .axil_rready(rready),
        .axil_rdata(rdata), .axil_rresp(rresp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // order: 0 = together, 1 = address first, 2 = data first
    task automatic axi_write(input logic [4:0] a, input logic [31:0] d,
                             input logic [3:0] s, input int order);
        bit a_done = 0, d_done = 0, a_hs, d_hs;
        int guard = 0;
        @(negedge aclk);
        awaddr = a; wdata = d; wstrb = s;
        if (order != 2) awvalid = 1;
        if (order != 1) wvalid = 1;
        while (!(a_done && d_done) && guard < 50) begin
            a_hs = awvalid && awready;
            d_hs = wvalid && wready;
            @(negedge aclk);
            guard++;
            if (a_hs) begin awvalid = 0; a_done = 1; end
            if (d_hs) begin wvalid = 0; d_done = 1; end
            if (order == 1 && a_done && !d_done) wvalid = 1;
            if (order == 2 && d_done && !a_done) awvalid = 1;
        end
        guard = 0;
        while (!bvalid && guard < 50) begin @(negedge aclk); guard++; end
        check("R2 bvalid", {31'd0, bvalid}, 32'd1);
        check("R2 bresp", {30'd0, bresp}, 32'd0);
        @(negedge aclk);
        check("R2 bvalid held", {31'd0, bvalid}, 32'd1);
        bready = 1;
        @(negedge aclk);
        bready = 0;
        check("R2 bvalid drop", {31'd0, bvalid}, 32'd0);
    endtask

    task automatic axi_read(input logic [4:0] a, output logic [31:0] d);
        logic [31:0] first;
        int guard = 0;
        @(negedge aclk);
        araddr = a; arvalid = 1;
        while (!arready && guard < 50) begin @(negedge aclk); guard++; end
        @(negedge aclk);
        arvalid = 0;
        guard = 0;
        while (!rvalid && guard < 50) begin @(negedge aclk); guard++; end
        first = rdata;
        check("R3 rresp", {30'd0, rresp}, 32'd0);
        @(negedge aclk);
        check("R3 rvalid held", {31'd0, rvalid}, 32'd1);
        check("R3 rdata stable", rdata, first);
        rready = 1;
        @(negedge aclk);
        rready = 0;
        d = first;
    endtask

    function automatic logic [31:0] ref_gcd(input logic [31:0] a, input logic [31:0] b);
        while (!(a == 0 || b == 0 || a == b)) begin
            if (a > b) a = a - b; else b = b - a;
        end
        return (a == 0) ? b : a;
    endfunction

    function automatic logic [31:0] ref_cnt(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] n = 1;
        while (!(a == 0 || b == 0 || a == b)) begin
            if (a > b) a = a - b; else b = b - a;
            n++;
        end
        return n;
    endfunction

    task automatic wait_ready();
        logic [31:0] st;
        int guard = 0;
        do begin
            axi_read(5'h00, st);
            guard++;
        end while (st[1] == 1'b0 && guard < 400);
        check("R6 ready after op", {31'd0, st[1]}, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 bvalid", {31'd0, bvalid}, 32'd0);
        check("R1 rvalid", {31'd0, rvalid}, 32'd0);
        axi_read(5'h00, v); check("R1 status", v, 32'h2);
        axi_read(5'h04, v); check("R1 opa", v, 32'h0);
        axi_read(5'h08, v); check("R1 opb", v, 32'h0);
        axi_read(5'h0C, v); check("R1 result", v, 32'h0);
        axi_read(5'h10, v); check("R1 count", v, 32'h0);
    endtask

    task automatic t_operands();
        logic [31:0] v;
        axi_write(5'h04, 32'h11223344, 4'hF, 0);
        axi_read(5'h04, v); check("R4 opa full", v, 32'h11223344);
        axi_write(5'h04, 32'hAABBCCDD, 4'b0010, 1);
        axi_read(5'h04, v); check("R4 opa lane1", v, 32'h1122CC44);
        axi_write(5'h08, 32'hCAFEF00D, 4'b1001, 2);
        axi_read(5'h08, v); check("R4 R2 opb data-first", v, 32'hCA00000D);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        axi_write(5'h0C, 32'hDEADBEEF, 4'hF, 0);
        axi_read(5'h0C, v); check("R5 result ignores write", v, 32'h0);
        axi_write(5'h10, 32'h12345678, 4'hF, 1);
        axi_read(5'h10, v); check("R5 count ignores write", v, 32'h0);
        axi_write(5'h00, 32'h2, 4'hF, 0);
        axi_read(5'h00, v); check("R5 ready read-only", v, 32'h2);
        axi_write(5'h14, 32'hFFFFFFFF, 4'hF, 0);
        axi_read(5'h14, v); check("R3 unmapped 0x14", v, 32'h0);
        axi_read(5'h18, v); check("R3 unmapped 0x18", v, 32'h0);
        axi_read(5'h1C, v); check("R3 unmapped 0x1C", v, 32'h0);
    endtask

    task automatic t_gcd(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] v;
        axi_write(5'h04, a, 4'hF, 0);
        axi_write(5'h08, b, 4'hF, 2);
        axi_write(5'h00, 32'h1, 4'h1, 1);
        wait_ready();
        axi_read(5'h0C, v); check("R7 result", v, ref_gcd(a, b));
        axi_read(5'h10, v); check("R8 count", v, ref_cnt(a, b));
        axi_write(5'h04, 32'h3, 4'hF, 0);
        axi_read(5'h10, v); check("R8 count frozen", v, ref_cnt(a, b));
    endtask

    task automatic t_busy();
        logic [31:0] v;
        axi_write(5'h04, 32'd1000, 4'hF, 0);
        axi_write(5'h08, 32'd1, 4'hF, 0);
        axi_write(5'h00, 32'h1, 4'h1, 0);
        axi_read(5'h00, v); check("R6 busy status", v, 32'h1);
        axi_write(5'h04, 32'd5, 4'hF, 0);
        axi_write(5'h08, 32'd5, 4'hF, 0);
        axi_write(5'h00, 32'h1, 4'h1, 0);
        wait_ready();
        axi_read(5'h0C, v); check("R9 result kept", v, 32'd1);
        axi_read(5'h10, v); check("R9 count kept", v, 32'd1000);
        axi_write(5'h00, 32'h1, 4'h0, 0);
        axi_read(5'h10, v); check("R6 no launch without lane0", v, 32'd1000);
    endtask

    initial begin
        repeat (150000) @(posedge aclk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge aclk);
        aresetn = 1;
        t_reset();
        t_operands();
        t_readonly();
        t_gcd(32'd12, 32'd8);
        t_gcd(32'd48, 32'd18);
        t_gcd(32'd17, 32'd5);
        t_gcd(32'd0, 32'd7);
        t_gcd(32'd9, 32'd0);
        t_gcd(32'd0, 32'd0);
        t_gcd(32'd21, 32'd21);
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule